// File: doc/BRIEF.md
# Write-Protect and Self-Timed Write Controller

This block sits beside the command engine of a serial nonvolatile memory. It holds the status byte, decides whether a requested array or status write may go ahead, and runs the self-timed programming cycle that follows an accepted request. The command engine raises a one-cycle commit strobe once a complete write sequence has ended with chip select going high. Separate strobes set and clear the write enable latch. An active-low protect input and two block-protect bits decide whether the write is refused.

An accepted request starts a counter that models the programming time. The counter length is a parameter in clock cycles, so a bench can make it short. While the cycle runs, the block shows busy and holds off new commands. The status byte stays readable throughout. When the cycle ends, an array request produces a one-cycle program strobe with the latched address, and a status request loads the new block-protect bits. In both cases the enable latch then clears.

Top module: `wr_guard_ctrl`

## Requirements
- R1: After reset, stat_o, bp_o, wel_o, busy_o and prog_o are all zero.
- R2: When idle with lock_ni high, arm_i sets wel_o and disarm_i clears it one cycle later. If both strobes arrive in the same cycle, disarm_i wins.
- R3: While lock_ni is low, wel_o is cleared one cycle later and stays clear, and arm_i has no effect.
- R4: An accepted commit raises busy_o in the next cycle, and busy_o stays high for exactly CYC_LEN cycles.
- R5: When an array cycle ends, prog_o is high for one cycle, in the cycle right after busy_o falls, and prog_addr_o carries the committed address.
- R6: wel_o is zero once a write cycle has finished.
- R7: A commit is refused (no busy_o, no prog_o) if wel_o is low or lock_ni is low in the commit cycle.
- R8: An array commit to a protected address is refused and wel_o is left unchanged. The protected region depends on bp_o: 0 protects nothing; 1 protects addresses whose two top bits are 11; 2 protects addresses whose top bit is 1; 3 protects all addresses.
- R9: A status commit loads bp_new_i into bp_o only when its cycle ends, and it never pulses prog_o. The status byte stat_o is laid out as follows: bit0 = busy, bit1 = wel, bits[3:2] = bp, and bits[7:4] = 0.
- R10: If lock_ni falls during a running cycle, wel_o still clears, but busy_o runs its full length and prog_o still fires.
- R11: While busy_o is high, arm_i, disarm_i, arr_commit_i and sr_commit_i are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lock_ni | input | 1 | Hardware write protect, active low |
| arm_i | input | 1 | Set-enable strobe |
| disarm_i | input | 1 | Clear-enable strobe |
| arr_commit_i | input | 1 | Array write request strobe |
| sr_commit_i | input | 1 | Status write request strobe |
| addr_i | input | ADDR_W | Target address of the array write |
| bp_new_i | input | 2 | New block-protect value for a status write |
| stat_o | output | 8 | Status byte |
| bp_o | output | 2 | Current block-protect bits |
| wel_o | output | 1 | Write enable latch |
| busy_o | output | 1 | Write cycle in progress |
| prog_o | output | 1 | One-cycle program strobe to the array |
| prog_addr_o | output | ADDR_W | Address that goes with prog_o |

## Verification
The strobes and the lock input act through one register, so wel_o and busy_o respond one cycle after the input is sampled. busy_o then stays high for CYC_LEN cycles. prog_o and the new bp_o appear in the cycle after the last busy cycle. The bench drives and samples on the falling clock edge and counts rising edges. For every accepted array request, the driver stores the cycle number in which prog_o is due, together with the address. The monitor compares each prog_o pulse against the oldest stored entry and flags any pulse that has no entry. Busy-length checks sample at CYC_LEN-1 and at CYC_LEN falling edges after the commit.

// File: rtl/wr_guard_pkg.sv
package wr_guard_pkg;
  typedef enum logic [1:0] {
    PROT_NONE = 2'd0,
    PROT_QTR  = 2'd1,
    PROT_HALF = 2'd2,
    PROT_ALL  = 2'd3
  } prot_e;

  typedef enum logic {
    OP_ARR = 1'b0,
    OP_SR  = 1'b1
  } op_e;

  localparam int unsigned STAT_W   = 8;
  localparam int unsigned ST_BUSY  = 0;
  localparam int unsigned ST_WEL   = 1;
  localparam int unsigned ST_BP_LO = 2;
endpackage

// File: rtl/wr_guard_region.sv
module wr_guard_region
  import wr_guard_pkg::*;
(
  input  prot_e      bp_i,
  input  logic [1:0] top_i,
  output logic       blocked_o
);
  always_comb begin
    unique case (bp_i)
      PROT_NONE: blocked_o = 1'b0;
      PROT_QTR:  blocked_o = &top_i;
      PROT_HALF: blocked_o = top_i[1];
      default:   blocked_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/wr_guard_timer.sv
module wr_guard_timer #(
  parameter int unsigned CYC_LEN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CNT_W = $clog2(CYC_LEN + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  assign done_o = busy_q && (cnt_q == '0);
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(CYC_LEN - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/wr_guard_latch.sv
module wr_guard_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lock_ni,
  input  logic busy_i,
  input  logic done_i,
  input  logic set_i,
  input  logic clr_i,
  output logic wel_o
);
  logic wel_q;

  assign wel_o = wel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              wel_q <= 1'b0;
    else if (!lock_ni)        wel_q <= 1'b0;
    else if (done_i)          wel_q <= 1'b0;
    else if (!busy_i) begin
      if (clr_i)              wel_q <= 1'b0; // clear beats set
      else if (set_i)         wel_q <= 1'b1;
    end
  end
endmodule

// File: rtl/wr_guard_ctrl.sv
module wr_guard_ctrl
  import wr_guard_pkg::*;
#(
  parameter int unsigned ADDR_W  = 9,
  parameter int unsigned CYC_LEN = 750000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lock_ni,
  input  logic              arm_i,
  input  logic              disarm_i,
  input  logic              arr_commit_i,
  input  logic              sr_commit_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        bp_new_i,
  output logic [7:0]        stat_o,
  output logic [1:0]        bp_o,
  output logic              wel_o,
  output logic              busy_o,
  output logic              prog_o,
  output logic [ADDR_W-1:0] prog_addr_o
);
  logic              blocked;
  logic              busy, done, wel;
  logic              acc_arr, acc_sr;
  prot_e             bp_q, bp_pend_q;
  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic              prog_q;

  wr_guard_region u_region (
    .bp_i      (bp_q),
    .top_i     (addr_i[ADDR_W-1 -: 2]),
    .blocked_o (blocked)
  );

  wr_guard_timer #(.CYC_LEN(CYC_LEN)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (acc_arr || acc_sr),
    .busy_o  (busy),
    .done_o  (done)
  );

  wr_guard_latch u_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lock_ni (lock_ni),
    .busy_i  (busy),
    .done_i  (done),
    .set_i   (arm_i),
    .clr_i   (disarm_i),
    .wel_o   (wel)
  );

  // array request has priority over a simultaneous status request
  assign acc_arr = arr_commit_i && !busy && wel && lock_ni && !blocked;
  assign acc_sr  = sr_commit_i && !arr_commit_i && !busy && wel && lock_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q      <= OP_ARR;
      addr_q    <= '0;
      bp_q      <= PROT_NONE;
      bp_pend_q <= PROT_NONE;
      prog_q    <= 1'b0;
    end else begin
      prog_q <= 1'b0;
      if (acc_arr) begin
        op_q   <= OP_ARR;
        addr_q <= addr_i;
      end else if (acc_sr) begin
        op_q      <= OP_SR;
        bp_pend_q <= prot_e'(bp_new_i);
      end
      if (done) begin
        if (op_q == OP_SR) bp_q   <= bp_pend_q;
        else               prog_q <= 1'b1;
      end
    end
  end

  always_comb begin
    stat_o                      = '0;
    stat_o[ST_BUSY]             = busy;
    stat_o[ST_WEL]              = wel;
    stat_o[ST_BP_LO+1:ST_BP_LO] = bp_q;
  end

  assign bp_o        = bp_q;
  assign wel_o       = wel;
  assign busy_o      = busy;
  assign prog_o      = prog_q;
  assign prog_addr_o = addr_q;
endmodule

// File: rtl/wr_guard_chk.sv
module wr_guard_chk #(
  parameter int unsigned CYC_LEN = 750000
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       lock_ni,
  input logic       arr_commit_i,
  input logic       sr_commit_i,
  input logic [1:0] bp_o,
  input logic       wel_o,
  input logic       busy_o,
  input logic       prog_o
);
  int unsigned run_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_cnt <= 0;
    else if (busy_o) run_cnt <= run_cnt + 1;
    else             run_cnt <= 0;
  end

  p_lock_clears_wel_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_ni |=> !wel_o);

  p_cycle_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (run_cnt == CYC_LEN));

  p_start_has_req_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(arr_commit_i || sr_commit_i));

  p_prog_after_cycle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_o |-> (!busy_o && $past(busy_o)));

  p_wel_cleared_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> !wel_o);

  p_no_start_locked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(lock_ni));

  p_bp_frozen_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($stable(bp_o) || !busy_o));
endmodule

bind wr_guard_ctrl wr_guard_chk #(.CYC_LEN(CYC_LEN)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .lock_ni      (lock_ni),
  .arr_commit_i (arr_commit_i),
  .sr_commit_i  (sr_commit_i),
  .bp_o         (bp_o),
  .wel_o        (wel_o),
  .busy_o       (busy_o),
  .prog_o       (prog_o)
);

// File: tb/test_wr_guard_ctrl.sv
module test_wr_guard_ctrl;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned AW  = 9;
  localparam int unsigned LEN = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lock_n = 1'b1, arm = 1'b0, disarm = 1'b0;
  logic          arr_c = 1'b0, sr_c = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [1:0]    bp_new = '0;
  logic [7:0]    stat;
  logic [1:0]    bp;
  logic          wel, busy, prog;
  logic [AW-1:0] prog_addr;

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 1'b0;
  int          exp_cyc[$];
  logic [AW-1:0] exp_adr[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wr_guard_ctrl #(.ADDR_W(AW), .CYC_LEN(LEN)) i_wr_guard_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .lock_ni(lock_n), .arm_i(arm), .disarm_i(disarm),
    .arr_commit_i(arr_c), .sr_commit_i(sr_c), .addr_i(addr), .bp_new_i(bp_new),
    .stat_o(stat), .bp_o(bp), .wel_o(wel), .busy_o(busy), .prog_o(prog),
    .prog_addr_o(prog_addr)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_arm();
    @(negedge clk) arm = 1'b1;
    @(negedge clk) arm = 1'b0;
  endtask

  task automatic do_disarm();
    @(negedge clk) disarm = 1'b1;
    @(negedge clk) disarm = 1'b0;
  endtask

  task automatic commit_arr(logic [AW-1:0] a, bit ok);
    @(negedge clk) begin arr_c = 1'b1; addr = a; end
    @(negedge clk) arr_c = 1'b0;
    if (ok) begin
      exp_cyc.push_back(cyc + LEN);
      exp_adr.push_back(a);
    end
  endtask

  task automatic commit_sr(logic [1:0] v);
    @(negedge clk) begin sr_c = 1'b1; bp_new = v; end
    @(negedge clk) sr_c = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    step(1);
  endtask

  task automatic set_bp(logic [1:0] v);
    do_arm();
    commit_sr(v);
    wait_idle();
    chk("R9 bp load", bp, v);
  endtask

  // scoreboard monitor for program strobes
  always @(negedge clk) begin
    if (rst_n && prog) begin
      checks++;
      if (exp_cyc.size() == 0) begin
        fails++;
        $display("FAIL R5 unexpected prog: actual addr %0h cyc %0d expected none", prog_addr, cyc);
      end else begin
        int ec;
        logic [AW-1:0] ea;
        ec = exp_cyc.pop_front();
        ea = exp_adr.pop_front();
        if (ec != cyc || ea !== prog_addr) begin
          fails++;
          $display("FAIL R5 prog: actual addr %0h cyc %0d expected addr %0h cyc %0d",
                   prog_addr, cyc, ea, ec);
        end
      end
    end
  end

  initial begin
    #(8 * 50000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    step(3);
    chk("R1 stat", stat, 8'h00);
    chk("R1 busy", busy, 1'b0);
    chk("R1 prog", prog, 1'b0);
    rst_n = 1'b1;
    step(2);
    chk("R1 after release", {bp, wel, busy, prog}, 5'b0);

    // R2
    do_arm();
    chk("R2 arm", wel, 1'b1);
    do_disarm();
    chk("R2 disarm", wel, 1'b0);
    @(negedge clk) begin arm = 1'b1; disarm = 1'b1; end
    @(negedge clk) begin arm = 1'b0; disarm = 1'b0; end
    chk("R2 disarm wins", wel, 1'b0);

    // R4 R5 R6 array cycle
    do_arm();
    commit_arr(9'h005, 1'b1);
    chk("R4 busy start", stat, 8'h03);
    step(LEN - 1);
    chk("R4 busy last", busy, 1'b1);
    step(1);
    chk("R4 busy end", busy, 1'b0);
    chk("R6 wel clear", wel, 1'b0);

    // R7 no enable
    commit_arr(9'h006, 1'b0);
    chk("R7 no wel", busy, 1'b0);
    step(LEN + 2);

    // R3 lock
    lock_n = 1'b0;
    do_arm();
    chk("R3 arm under lock", wel, 1'b0);
    lock_n = 1'b1;
    do_arm();
    chk("R3 arm after unlock", wel, 1'b1);
    lock_n = 1'b0;
    step(1);
    chk("R3 lock clears wel", wel, 1'b0);
    lock_n = 1'b1;
    do_arm();
    @(negedge clk) begin lock_n = 1'b0; arr_c = 1'b1; addr = 9'h007; end
    @(negedge clk) arr_c = 1'b0;
    chk("R7 locked commit", busy, 1'b0);
    lock_n = 1'b1;
    step(LEN + 2);

    // R9 status write
    do_arm();
    commit_sr(2'd1);
    chk("R9 busy", busy, 1'b1);
    chk("R9 bp held during cycle", bp, 2'd0);
    wait_idle();
    chk("R9 stat layout", stat, 8'h04);

    // R8 quarter
    do_arm();
    commit_arr(9'h180, 1'b0);
    chk("R8 quarter refused", busy, 1'b0);
    chk("R8 wel kept", wel, 1'b1);
    commit_arr(9'h17F, 1'b1);
    chk("R8 below quarter", busy, 1'b1);
    wait_idle();

    // R8 half
    set_bp(2'd2);
    do_arm();
    commit_arr(9'h100, 1'b0);
    chk("R8 half refused", busy, 1'b0);
    commit_arr(9'h0FF, 1'b1);
    chk("R8 below half", busy, 1'b1);
    wait_idle();

    // R10 R11
    do_arm();
    commit_arr(9'h010, 1'b1);
    step(2);
    do_disarm();
    chk("R11 disarm ignored", wel, 1'b1);
    commit_arr(9'h020, 1'b0);
    commit_sr(2'd3);
    lock_n = 1'b0;
    step(1);
    chk("R10 wel cleared", wel, 1'b0);
    chk("R10 busy kept", busy, 1'b1);
    lock_n = 1'b1;
    wait_idle();
    chk("R11 sr ignored", bp, 2'd2);

    // R8 all
    set_bp(2'd3);
    do_arm();
    commit_arr(9'h000, 1'b0);
    chk("R8 all refused", busy, 1'b0);
    step(LEN + 3);
    chk("R5 scoreboard drained", exp_cyc.size(), 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule